// File: doc/BRIEF.md
# Serial-Fed LCD Segment Driver with Cascade Output

This block turns a serial bit stream into a parallel pattern of LCD segment drives. One bit arrives on each rising edge of the serial clock and is pushed into a shift chain whose depth equals the number of segments. The bit that falls off the far end of the chain appears on a cascade output. That output changes on the falling edge, so a second driver clocked by the same clock can take its input from it without a hold race.

A separate display latch holds the pattern that is shown. It is written only when a load pulse completes: the load input has to be held high for a fixed number of rising edges. The commit happens on the last of those edges. The word captured includes the bit shifted in on that same edge, so a host raises the load input for the final eight bits of a frame.

Every latched bit is combined with the backplane square wave through an XOR gate. A lit segment therefore swings in antiphase to the backplane, and a dark one follows it in phase. This path has no clock in it.

Top module: `lcdseg_driver`

## Requirements
- R1: On every rising edge of `clk`, `ser_din` enters shift stage SEG_COUNT-1 and each stage k (k>0) moves its bit to stage k-1.
- R2: After SEG_COUNT bits have been shifted in LSB first and committed, the first bit sent drives `seg[0]` and the last bit sent drives `seg[SEG_COUNT-1]`.
- R3: `ser_dout` shows shift stage 0 and changes only on the falling edge of `clk`. It therefore equals the `ser_din` value sampled SEG_COUNT rising edges earlier, and 0 if there was no such edge since reset.
- R4: While `rst_n` is low (asynchronous, active low), the shift chain, the display latch, the load counter and `ser_dout` are all cleared, so every `seg` bit equals `backplane`.
- R5: Each `seg[i]` equals display-latch bit i XOR `backplane`, and follows a change of `backplane` with no clock edge.
- R6: With the default counted load mode, the display latch is written on the LOAD_DELAY-th (default 8th) consecutive rising edge at which `load` is high. It captures the shift chain as it stands after that edge's shift.
- R7: If `load` falls before LOAD_DELAY high edges have been seen, the count restarts from zero and the display does not change. A later high level starts a new count.
- R8: A `load` level held high beyond LOAD_DELAY edges commits exactly once. Shifting continues afterwards without altering the display until `load` has been low and the count completes again.
- R9: On every rising edge that is not a commit edge, the display latch and hence `seg` keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial data in, LSB first |
| load | input | 1 | Load request; commit after LOAD_DELAY high edges |
| backplane | input | 1 | Backplane square wave |
| ser_dout | output | 1 | Cascade data out, falling-edge timed |
| seg | output | SEG_COUNT | Segment drives, latch XOR backplane |

## Verification
Shifting and committing share an edge: the commit edge also shifts in the final bit of the frame. The bench raises `load` for exactly the last eight bits of each frame and compares the segments after that edge with a queue-based model, which only passes if the captured word already contains that bit. The backplane is toggled inside every cycle, so both levels are judged against the latch at once. A reset issued in the middle of a stream shows whether the cascade output and the display clear together.

// File: rtl/lcdseg_pkg.sv
`timescale 1ns/1ps
package lcdseg_pkg;

   typedef enum logic {
      LOAD_IMMEDIATE = 1'b0,
      LOAD_COUNTED   = 1'b1
   } load_mode_e;

   function automatic int unsigned cnt_width(input int unsigned delay);
      int unsigned w;
      w = 1;
      while ((1 << w) <= delay) w++;
      return w;
   endfunction

endpackage

// File: rtl/lcdseg_shifter.sv
`timescale 1ns/1ps
module lcdseg_shifter #(
   parameter int unsigned WIDTH = 46
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   output logic [WIDTH-1:0] chain_o,
   output logic [WIDTH-1:0] chain_next_o,
   output logic             dout_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("lcdseg_shifter: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q;
   logic             dout_q;

   assign chain_next_o = {din, chain_q[WIDTH-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_next_o;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) dout_q <= 1'b0;
      else        dout_q <= chain_q[0];
   end

   assign chain_o = chain_q;
   assign dout_o  = dout_q;

   // R1: every stage advances one position towards stage 0
   a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> chain_q[WIDTH-2:0] == $past(chain_q[WIDTH-1:1]));

   // R1: the new bit lands in the top stage
   a_r1_entry: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> chain_q[WIDTH-1] == $past(din));

   // R3: the falling-edge copy seen at the next rising edge is the bottom stage
   a_r3_cascade: assert property (@(posedge clk) disable iff (!rst_n)
      dout_q == chain_q[0]);

endmodule

// File: rtl/lcdseg_load_ctrl.sv
`timescale 1ns/1ps
module lcdseg_load_ctrl
   import lcdseg_pkg::*;
#(
   parameter int unsigned LOAD_DELAY = 8,
   parameter load_mode_e  LOAD_MODE  = LOAD_COUNTED
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic commit_o
);

   localparam int unsigned CNT_W = cnt_width(LOAD_DELAY);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LOAD_DELAY - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(LOAD_DELAY);

   generate
      if (LOAD_DELAY < 1) begin : g_bad_delay
         $error("lcdseg_load_ctrl: LOAD_DELAY must be at least 1");
      end

      if (LOAD_MODE == LOAD_COUNTED) begin : g_counted
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] cnt_d;

         always_comb begin
            if (!load)              cnt_d = '0;
            else if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
            else                    cnt_d = cnt_q;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
         end

         assign commit_o = load && (cnt_q == LAST);

         // R7: a low load level always restarts the count
         a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> cnt_q == '0);

         // R8: one commit per load pulse
         a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
            commit_o |=> !commit_o);

         // R6: count never passes the saturation point
         a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= FULL);
      end else begin : g_immediate
         assign commit_o = load;
      end
   endgenerate

endmodule

// File: rtl/lcdseg_latch.sv
`timescale 1ns/1ps
module lcdseg_latch #(
   parameter int unsigned WIDTH = 46
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [WIDTH-1:0] word_in,
   input  logic             bp,
   output logic [WIDTH-1:0] latch_o,
   output logic [WIDTH-1:0] seg_o
);

   logic [WIDTH-1:0] latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      latch_q <= '0;
      else if (commit) latch_q <= word_in;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_seg
      assign seg_o[i] = latch_q[i] ^ bp;
   end

   assign latch_o = latch_q;

   // R9: no commit, no change
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(latch_q));

endmodule

// File: rtl/lcdseg_driver.sv
`timescale 1ns/1ps
module lcdseg_driver
   import lcdseg_pkg::*;
#(
   parameter int unsigned SEG_COUNT  = 46,
   parameter int unsigned LOAD_DELAY = 8,
   parameter load_mode_e  LOAD_MODE  = LOAD_COUNTED
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_din,
   input  logic                 load,
   input  logic                 backplane,
   output logic                 ser_dout,
   output logic [SEG_COUNT-1:0] seg
);

   logic [SEG_COUNT-1:0] chain;
   logic [SEG_COUNT-1:0] chain_next;
   logic [SEG_COUNT-1:0] word;
   logic [SEG_COUNT-1:0] latch;
   logic                 commit;

   lcdseg_shifter #(.WIDTH(SEG_COUNT)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .din          (ser_din),
      .chain_o      (chain),
      .chain_next_o (chain_next),
      .dout_o       (ser_dout)
   );

   lcdseg_load_ctrl #(.LOAD_DELAY(LOAD_DELAY), .LOAD_MODE(LOAD_MODE)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .commit_o (commit)
   );

   generate
      if (LOAD_MODE == LOAD_COUNTED) begin : g_word_post
         assign word = chain_next;
      end else begin : g_word_pre
         assign word = chain;
      end
   endgenerate

   lcdseg_latch #(.WIDTH(SEG_COUNT)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (commit),
      .word_in (word),
      .bp      (backplane),
      .latch_o (latch),
      .seg_o   (seg)
   );

   // R6: the latch takes the word presented on the commit edge
   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> latch == $past(word));

   // R6: in counted mode a commit needs load high on the edge before too
   generate
      if (LOAD_MODE == LOAD_COUNTED && LOAD_DELAY > 1) begin : g_chk_run
         a_r6_run: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(load) |-> !commit);
      end
   endgenerate

endmodule

// File: tb/lcdseg_driver_tb.sv
`timescale 1ns/1ps
module lcdseg_driver_tb_top;

   localparam int N  = 46;
   localparam int LD = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ser_din = 1'b0;
   logic         load = 1'b0;
   logic         backplane = 1'b0;
   logic         ser_dout;
   logic [N-1:0] seg;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   lcdseg_driver dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_din   (ser_din),
      .load      (load),
      .backplane (backplane),
      .ser_dout  (ser_dout),
      .seg       (seg)
   );

   // reference model
   bit           hist[$];
   int           m_cnt;
   logic [N-1:0] m_lat;

   task automatic model_clear();
      hist.delete();
      for (int i = 0; i < N; i++) hist.push_back(1'b0);
      m_cnt = 0;
      m_lat = '0;
   endtask

   function automatic logic [N-1:0] model_word();
      logic [N-1:0] w;
      for (int i = 0; i < N; i++) w[i] = hist[i];
      return w;
   endfunction

   function automatic logic [N-1:0] exp_seg();
      return m_lat ^ {N{backplane}};
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // one serial clock: inputs applied now, checks after both edges
   task automatic step(input bit d, input bit ld);
      ser_din = d;
      load    = ld;
      @(posedge clk);
      hist.push_back(d);
      void'(hist.pop_front());
      if (ld) begin
         m_cnt++;
         if (m_cnt == LD) m_lat = model_word();
      end else begin
         m_cnt = 0;
      end
      #1;
      chk(seg === exp_seg(), "R6/R9 seg", seg, exp_seg());
      backplane = ~backplane;
      #0.5;
      chk(seg === exp_seg(), "R5 backplane", seg, exp_seg());
      @(negedge clk);
      #0.5;
      chk(ser_dout === hist[0], "R3 cascade", {{(N-1){1'b0}}, ser_dout},
          {{(N-1){1'b0}}, hist[0]});
   endtask

   task automatic send_frame(input logic [N-1:0] w);
      for (int i = 0; i < N; i++) step(w[i], i >= N - LD);
   endtask

   logic [N-1:0] pat_a = 46'h22A5C3F01E96;
   logic [N-1:0] pat_b = 46'h1D3B_0F5A_C6E1;
   logic [N-1:0] held;

   initial begin
      model_clear();
      #7;
      // R4: reset state, both backplane levels
      chk(seg === {N{1'b0}}, "R4 reset bp=0", seg, '0);
      backplane = 1'b1;
      #0.5;
      chk(seg === {N{1'b1}}, "R4 reset bp=1", seg, {N{1'b1}});
      chk(ser_dout === 1'b0, "R4 reset dout", {{(N-1){1'b0}}, ser_dout}, '0);
      @(negedge clk);
      #0.5;
      rst_n = 1'b1;

      // R1/R2: first frame, load high for the last eight bits
      send_frame(pat_a);
      chk((seg ^ {N{backplane}}) === pat_a, "R2 frame A order", seg ^ {N{backplane}}, pat_a);

      // R9: shifting with load low keeps the display
      for (int i = 0; i < 30; i++) step(i[0] ^ i[2], 1'b0);
      chk((seg ^ {N{backplane}}) === pat_a, "R9 hold frame A", seg ^ {N{backplane}}, pat_a);

      // R7: load dropped after five edges, then a short second attempt
      for (int i = 0; i < 5; i++) step(i[1], 1'b1);
      step(1'b1, 1'b0);
      for (int i = 0; i < LD - 1; i++) step(i[0], 1'b1);
      step(1'b0, 1'b0);
      chk((seg ^ {N{backplane}}) === pat_a, "R7 aborted load", seg ^ {N{backplane}}, pat_a);

      // R8: long load pulse commits once, then holds
      for (int i = 0; i < 20; i++) begin
         step(i[0] ^ i[3], 1'b1);
         if (i == LD - 1) held = seg ^ {N{backplane}};
      end
      chk((seg ^ {N{backplane}}) === held, "R8 single commit", seg ^ {N{backplane}}, held);
      step(1'b0, 1'b0);

      // R2: second frame with a different pattern
      send_frame(pat_b);
      chk((seg ^ {N{backplane}}) === pat_b, "R2 frame B order", seg ^ {N{backplane}}, pat_b);
      for (int i = 0; i < N; i++) step(pat_a[i], 1'b0);

      // R4: asynchronous reset in mid-stream
      for (int i = 0; i < 10; i++) step(1'b1, 1'b1 && i < 4);
      rst_n = 1'b0;
      model_clear();
      #0.5;
      chk(seg === {N{backplane}}, "R4 mid reset seg", seg, {N{backplane}});
      chk(ser_dout === 1'b0, "R4 mid reset dout", {{(N-1){1'b0}}, ser_dout}, '0);
      @(negedge clk);
      #0.5;
      rst_n = 1'b1;
      send_frame(~pat_b);
      chk((seg ^ {N{backplane}}) === ~pat_b, "R2 frame after reset",
          seg ^ {N{backplane}}, ~pat_b);
      for (int i = 0; i < N + 4; i++) step(1'b0, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule